// File: doc/BRIEF.md
# Banked NOVRAM Strobe Decoder

This block is the control front end of a byte-wide nonvolatile RAM module built from four 2K×8 banks. It takes the module's four active-low strobes (chip select, write, nonvolatile select, output enable), a 13-bit byte address and the incoming bus byte. The strobes, address and bus byte pass through matched synchronizer stages into the system clock domain. From the synchronized strobe pattern the block picks one mode: idle, RAM read, RAM write, command write, array recall, or an illegal pattern. The two top address bits choose which bank receives each request.

The RAM arrays and the nonvolatile transfer engines are outside the block. They connect through per-bank one-hot request lines and a shared latched write address and data byte. Reads are returned on per-bank data inputs. The block chooses the byte for the addressed bank and drives it onto the bus only while a read is in progress. The bus is a separate output byte with an enable, so that the pad ring can build the tri-state driver.

A write or command write opens when the second of chip select and write goes low, and the address is captured then. It closes when the first of the two goes high, and the bus byte is captured then, with the request pulse issued for one cycle. A recall opens when chip select, nonvolatile select and output enable are all low while write is high. It gives one pulse to the selected bank only.

Top module: `nvram_bank_ctrl`

## Requirements
- R1: After reset, the bus enable is low, the error flag is low and no bank request line is high.
- R2: While chip select is high, the bus enable stays low and no request is issued, whatever the other three strobes do.
- R3: Chip select and write low with nonvolatile select high gives exactly one write pulse. The pulse goes to the selected bank, with wrAddr equal to the low 11 address bits and wrData equal to the bus byte. Output enable has no effect on this, and the bus is not driven while write is low.
- R4: Chip select and output enable low with write and nonvolatile select high raises busOe. busOut then carries the selected bank's read byte, bankRead is one-hot on that bank and rdAddr equals the low 11 address bits.
- R5: Chip select, nonvolatile select and output enable low with write high gives one recall pulse to the selected bank only. The pulse is issued once per entry into the pattern, however long the pattern is held.
- R6: busOe is low whenever chip select or output enable is high, or nonvolatile select is low.
- R7: The write address is the one present when the later of chip select and write falls. The data is the bus byte present when the earlier of the two rises.
- R8: Address bits 12:11, read as an unsigned value i, select bank i. Bank i's read byte is bankRdData bits [8i+7:8i], and request bit i goes to bank i.
- R9: Chip select, write and nonvolatile select low with output enable high gives exactly one command pulse on bankCmd, not a write pulse. It carries the same address and data as a write.
- R10: All four strobes low sets illegalErr. The flag stays set until reset, no request is issued for the aborted access, and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip select strobe, active low |
| weN | input | 1 | Write strobe, active low |
| nvN | input | 1 | Nonvolatile select strobe, active low |
| oeN | input | 1 | Output enable strobe, active low |
| addr | input | 13 | Byte address; bits 12:11 select the bank |
| busIn | input | 8 | Byte arriving from the bus |
| bankRdData | input | 32 | Read bytes of the four banks, bank i at [8i+7:8i] |
| busOut | output | 8 | Byte to drive onto the bus |
| busOe | output | 1 | Bus driver enable |
| bankRead | output | 4 | One-hot read select per bank |
| rdAddr | output | 11 | In-bank read address |
| bankWrite | output | 4 | One-cycle RAM write request per bank |
| bankCmd | output | 4 | One-cycle command write request per bank |
| bankRecall | output | 4 | One-cycle array recall request per bank |
| wrAddr | output | 11 | Latched in-bank write address |
| wrData | output | 8 | Latched write byte |
| illegalErr | output | 1 | Sticky illegal strobe pattern flag |

## Verification
The checks on the request pulses (one bank at a time, single-cycle pulses) assume that the strobes change one at a time, a few cycles apart. The address and bus byte must also stay steady across the synchronizer delay around each strobe edge. If two strobes moved in the same sampled cycle, a closing write and an opening recall could fall together. Every bench task therefore moves one strobe per step and waits several cycles between steps. It sets the address and data before the opening edge and holds them after the closing edge.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

  // Strobes from the control to the datapath, one cycle wide except readEn
  typedef struct packed {
    logic capAddr;    // capture address (access opens)
    logic capData;    // capture bus byte (write closes)
    logic fireWrite;  // issue RAM write
    logic fireCmd;    // issue command write
    logic fireRecall; // issue recall
    logic readEn;     // read pattern present (level)
  } ctlStrobe_t;

endpackage

// File: rtl/nvb_sync.sv
module nvb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
  import nvb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  input  logic       nvN,
  input  logic       oeN,
  output ctlStrobe_t ctl,
  output logic       illegalErr
);
  localparam int NUM_STROBES = 4;

  logic [NUM_STROBES-1:0] strobeSync;

  nvb_sync #(
    .WIDTH    (NUM_STROBES),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({NUM_STROBES{1'b1}})
  ) uStrobeSync (
    .clk (clk),
    .rstN(rstN),
    .din ({ceN, weN, nvN, oeN}),
    .dout(strobeSync)
  );

  // Active-high views of the synchronized strobes
  logic ceA, weA, nvA, oeA;
  assign ceA = ~strobeSync[3];
  assign weA = ~strobeSync[2];
  assign nvA = ~strobeSync[1];
  assign oeA = ~strobeSync[0];

  logic wrAct, recallAct, illegalNow;
  assign wrAct      = ceA & weA;
  assign recallAct  = ceA & nvA & oeA & ~weA;
  assign illegalNow = ceA & weA & nvA & oeA;

  logic wrActQ, recallActQ, isCmdQ, abortQ, errQ;
  logic wrStart, wrEnd, recallStart;

  assign wrStart     = wrAct & ~wrActQ;
  assign wrEnd       = ~wrAct & wrActQ;
  assign recallStart = recallAct & ~recallActQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ     <= 1'b0;
      recallActQ <= 1'b0;
      isCmdQ     <= 1'b0;
      abortQ     <= 1'b0;
      errQ       <= 1'b0;
    end else begin
      wrActQ     <= wrAct;
      recallActQ <= recallAct;
      if (wrStart) begin
        isCmdQ <= nvA;
        abortQ <= illegalNow;
      end else if (wrAct && illegalNow) begin
        abortQ <= 1'b1;
      end
      if (illegalNow) errQ <= 1'b1;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.capAddr    = wrStart;
    ctl.capData    = wrEnd;
    ctl.fireWrite  = wrEnd & ~abortQ & ~isCmdQ;
    ctl.fireCmd    = wrEnd & ~abortQ & isCmdQ;
    ctl.fireRecall = recallStart;
    ctl.readEn     = ceA & ~weA & ~nvA & oeA;
  end

  assign illegalErr = errQ;

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);

  assert_single_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fireWrite | ctl.fireCmd) |=> !(ctl.fireWrite | ctl.fireCmd));

  assert_single_recall_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fireRecall |=> !ctl.fireRecall);

endmodule

// File: rtl/nvb_datapath.sv
module nvb_datapath
  import nvb_pkg::*;
#(
  parameter int BANK_BITS   = 2,
  parameter int BANK_AW     = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    ctl,
  input  logic [BANK_BITS+BANK_AW-1:0]  addr,
  input  logic [DATA_W-1:0]             busIn,
  input  logic [(1<<BANK_BITS)*DATA_W-1:0] bankRdData,
  output logic [DATA_W-1:0]             busOut,
  output logic                          busOe,
  output logic [(1<<BANK_BITS)-1:0]     bankRead,
  output logic [BANK_AW-1:0]            rdAddr,
  output logic [(1<<BANK_BITS)-1:0]     bankWrite,
  output logic [(1<<BANK_BITS)-1:0]     bankCmd,
  output logic [(1<<BANK_BITS)-1:0]     bankRecall,
  output logic [BANK_AW-1:0]            wrAddr,
  output logic [DATA_W-1:0]             wrData
);
  localparam int ADDR_W    = BANK_BITS + BANK_AW;
  localparam int NUM_BANKS = 1 << BANK_BITS;

  logic [ADDR_W-1:0] addrSync;
  logic [DATA_W-1:0] dataSync;

  nvb_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) uAddrSync (
    .clk(clk), .rstN(rstN), .din(addr), .dout(addrSync));

  nvb_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) uDataSync (
    .clk(clk), .rstN(rstN), .din(busIn), .dout(dataSync));

  logic [BANK_BITS-1:0] selNow, selLatched;
  logic [ADDR_W-1:0]    addrLatch;
  logic [DATA_W-1:0]    dataLatch;

  assign selNow     = addrSync[ADDR_W-1 -: BANK_BITS];
  assign selLatched = addrLatch[ADDR_W-1 -: BANK_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
      dataLatch <= '0;
    end else begin
      if (ctl.capAddr) addrLatch <= addrSync;
      if (ctl.capData) dataLatch <= dataSync;
    end
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bankWrite[g]  <= 1'b0;
          bankCmd[g]    <= 1'b0;
          bankRecall[g] <= 1'b0;
        end else begin
          bankWrite[g]  <= ctl.fireWrite  && (selLatched == BANK_BITS'(g));
          bankCmd[g]    <= ctl.fireCmd    && (selLatched == BANK_BITS'(g));
          bankRecall[g] <= ctl.fireRecall && (selNow     == BANK_BITS'(g));
        end
      end
      assign bankRead[g] = ctl.readEn && (selNow == BANK_BITS'(g));
    end
  endgenerate

  assign busOe  = ctl.readEn;
  assign busOut = ctl.readEn ? bankRdData[selNow*DATA_W +: DATA_W] : '0;
  assign rdAddr = addrSync[BANK_AW-1:0];
  assign wrAddr = addrLatch[BANK_AW-1:0];
  assign wrData = dataLatch;

  assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankWrite | bankCmd | bankRecall));

  assert_read_select_R4: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> $onehot(bankRead));

endmodule

// File: rtl/nvram_bank_ctrl.sv
module nvram_bank_ctrl
  import nvb_pkg::*;
#(
  parameter int BANK_BITS   = 2,
  parameter int BANK_AW     = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              ceN,
  input  logic                              weN,
  input  logic                              nvN,
  input  logic                              oeN,
  input  logic [BANK_BITS+BANK_AW-1:0]      addr,
  input  logic [DATA_W-1:0]                 busIn,
  input  logic [(1<<BANK_BITS)*DATA_W-1:0]  bankRdData,
  output logic [DATA_W-1:0]                 busOut,
  output logic                              busOe,
  output logic [(1<<BANK_BITS)-1:0]         bankRead,
  output logic [BANK_AW-1:0]                rdAddr,
  output logic [(1<<BANK_BITS)-1:0]         bankWrite,
  output logic [(1<<BANK_BITS)-1:0]         bankCmd,
  output logic [(1<<BANK_BITS)-1:0]         bankRecall,
  output logic [BANK_AW-1:0]                wrAddr,
  output logic [DATA_W-1:0]                 wrData,
  output logic                              illegalErr
);
  ctlStrobe_t ctl;

  nvb_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .ceN(ceN), .weN(weN), .nvN(nvN), .oeN(oeN),
    .ctl(ctl), .illegalErr(illegalErr));

  nvb_datapath #(
    .BANK_BITS(BANK_BITS), .BANK_AW(BANK_AW),
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .addr(addr), .busIn(busIn), .bankRdData(bankRdData),
    .busOut(busOut), .busOe(busOe), .bankRead(bankRead), .rdAddr(rdAddr),
    .bankWrite(bankWrite), .bankCmd(bankCmd), .bankRecall(bankRecall),
    .wrAddr(wrAddr), .wrData(wrData));

  // A flagged illegal pattern never leaves the bus driven afterwards
  assert_no_drive_after_err_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(illegalErr) |-> !busOe);

endmodule

// File: tb/nvram_bank_ctrl_test.sv
module nvram_bank_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, weN = 1'b1, nvN = 1'b1, oeN = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  busIn = '0;
  logic [31:0] bankRdData = 32'hD4C3B2A1;
  logic [7:0]  busOut;
  logic        busOe;
  logic [3:0]  bankRead, bankWrite, bankCmd, bankRecall;
  logic [10:0] rdAddr, wrAddr;
  logic [7:0]  wrData;
  logic        illegalErr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvram_bank_ctrl uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .nvN(nvN), .oeN(oeN),
    .addr(addr), .busIn(busIn), .bankRdData(bankRdData),
    .busOut(busOut), .busOe(busOe), .bankRead(bankRead), .rdAddr(rdAddr),
    .bankWrite(bankWrite), .bankCmd(bankCmd), .bankRecall(bankRecall),
    .wrAddr(wrAddr), .wrData(wrData), .illegalErr(illegalErr));

  // Pulse monitor, sampled mid-cycle
  int wrCount = 0, cmdCount = 0, rcCount = 0, badPulse = 0;
  logic [3:0]  lastMask;
  logic [10:0] lastAddr;
  logic [7:0]  lastData;
  always @(negedge clk) begin
    if (rstN) begin
      if ($countones(bankWrite | bankCmd | bankRecall) > 1) badPulse++;
      if (|bankWrite)  begin wrCount++;  lastMask = bankWrite;  lastAddr = wrAddr; lastData = wrData; end
      if (|bankCmd)    begin cmdCount++; lastMask = bankCmd;    lastAddr = wrAddr; lastData = wrData; end
      if (|bankRecall) begin rcCount++;  lastMask = bankRecall; end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic stepTo(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    check({31'd0, busOe}, 0, "R1 busOe");
    check({31'd0, illegalErr}, 0, "R1 illegalErr");
    check({16'd0, bankWrite, bankCmd, bankRecall, bankRead}, 0, "R1 requests");
  endtask

  task automatic testDeselect();
    int w0 = wrCount, c0 = cmdCount, r0 = rcCount;
    stepTo(1); weN = 1'b0; oeN = 1'b0; addr = 13'h0123;
    waitCyc(5);
    check({31'd0, busOe}, 0, "R2 bus with ce high");
    stepTo(1); nvN = 1'b0;
    waitCyc(5);
    check({31'd0, busOe}, 0, "R2 bus with ce high, nv low");
    check({31'd0, illegalErr}, 0, "R2 no error with ce high");
    stepTo(1); weN = 1'b1; stepTo(2); nvN = 1'b1; stepTo(2); oeN = 1'b1;
    waitCyc(5);
    check(wrCount + cmdCount + rcCount, w0 + c0 + r0, "R2 no requests");
  endtask

  task automatic testRead(input logic [1:0] bank, input logic [10:0] low);
    stepTo(1); addr = {bank, low};
    stepTo(2); ceN = 1'b0;
    stepTo(2); oeN = 1'b0;
    waitCyc(5);
    check({31'd0, busOe}, 1, "R4 busOe");
    check({24'd0, busOut}, {24'd0, bankRdData[bank*8 +: 8]}, "R8 read byte of bank");
    check({28'd0, bankRead}, {28'd0, 4'b0001 << bank}, "R8 bankRead one-hot");
    check({21'd0, rdAddr}, {21'd0, low}, "R4 rdAddr");
    stepTo(1); oeN = 1'b1;
    waitCyc(5);
    check({31'd0, busOe}, 0, "R6 oe high releases bus");
    stepTo(1); ceN = 1'b1;
    waitCyc(3);
  endtask

  task automatic testWrite(input logic [1:0] bank, input logic [10:0] low,
                           input logic [7:0] data, input bit oeLow);
    int w0 = wrCount, c0 = cmdCount;
    stepTo(1); addr = {bank, low}; busIn = data;
    stepTo(1); oeN = !oeLow;
    stepTo(2); ceN = 1'b0;
    stepTo(2); weN = 1'b0;
    waitCyc(5);
    check({31'd0, busOe}, 0, "R3 bus not driven while writing");
    stepTo(1); weN = 1'b1;
    waitCyc(5);
    stepTo(1); ceN = 1'b1;
    stepTo(2); oeN = 1'b1;
    waitCyc(5);
    check(wrCount, w0 + 1, "R3 one write pulse");
    check(cmdCount, c0, "R3 no command pulse");
    check({28'd0, lastMask}, {28'd0, 4'b0001 << bank}, "R8 write bank");
    check({21'd0, lastAddr}, {21'd0, low}, "R3 wrAddr");
    check({24'd0, lastData}, {24'd0, data}, "R3 wrData");
  endtask

  task automatic testLatchOrder();
    int w0 = wrCount;
    stepTo(1); addr = {2'd2, 11'h2B4}; busIn = 8'h11;
    stepTo(2); weN = 1'b0;          // write falls first
    stepTo(3); ceN = 1'b0;          // chip select falls last: address taken
    stepTo(5); addr = {2'd1, 11'h0F0}; busIn = 8'h22;
    stepTo(5); busIn = 8'h3C;
    stepTo(4); ceN = 1'b1;          // chip select rises first: data taken
    stepTo(4); busIn = 8'h99;
    stepTo(3); weN = 1'b1;
    waitCyc(6);
    check(wrCount, w0 + 1, "R7 single write");
    check({28'd0, lastMask}, 32'h4, "R7 bank from address at later fall");
    check({21'd0, lastAddr}, 32'h2B4, "R7 address at later fall");
    check({24'd0, lastData}, 32'h3C, "R7 data at earlier rise");
  endtask

  task automatic testCommand(input logic [1:0] bank, input logic [10:0] low, input logic [7:0] data);
    int w0 = wrCount, c0 = cmdCount;
    stepTo(1); addr = {bank, low}; busIn = data;
    stepTo(1); nvN = 1'b0;
    stepTo(2); ceN = 1'b0;
    stepTo(2); weN = 1'b0;
    waitCyc(5);
    stepTo(1); weN = 1'b1;
    stepTo(5); ceN = 1'b1;
    stepTo(2); nvN = 1'b1;
    waitCyc(5);
    check(cmdCount, c0 + 1, "R9 one command pulse");
    check(wrCount, w0, "R9 no RAM write");
    check({28'd0, lastMask}, {28'd0, 4'b0001 << bank}, "R9 command bank");
    check({21'd0, lastAddr}, {21'd0, low}, "R9 command address");
    check({24'd0, lastData}, {24'd0, data}, "R9 command data");
  endtask

  task automatic testRecall(input logic [1:0] bank);
    int r0 = rcCount;
    stepTo(1); addr = {bank, 11'h055};
    stepTo(1); nvN = 1'b0;
    stepTo(2); oeN = 1'b0;
    stepTo(2); ceN = 1'b0;
    waitCyc(10);
    check(rcCount, r0 + 1, "R5 one recall pulse while held");
    check({28'd0, lastMask}, {28'd0, 4'b0001 << bank}, "R5 recall bank only");
    check({31'd0, busOe}, 0, "R6 nv low keeps bus released");
    stepTo(1); ceN = 1'b1;
    stepTo(2); oeN = 1'b1;
    stepTo(2); nvN = 1'b1;
    waitCyc(5);
    check(rcCount, r0 + 1, "R5 no pulse on exit");
  endtask

  task automatic testIllegal();
    int total0 = wrCount + cmdCount + rcCount;
    stepTo(1); weN = 1'b0;
    stepTo(2); nvN = 1'b0;
    stepTo(2); oeN = 1'b0;
    stepTo(2); ceN = 1'b0;
    waitCyc(5);
    check({31'd0, illegalErr}, 1, "R10 error set");
    check({31'd0, busOe}, 0, "R10 bus released");
    stepTo(1); ceN = 1'b1;
    stepTo(2); oeN = 1'b1;
    stepTo(2); nvN = 1'b1;
    stepTo(2); weN = 1'b1;
    waitCyc(6);
    check(wrCount + cmdCount + rcCount, total0, "R10 no request for illegal access");
    testWrite(2'd1, 11'h001, 8'h5A, 1'b0);
    check({31'd0, illegalErr}, 1, "R10 error stays set");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    testReset();
    stepTo(2); rstN = 1'b1;
    waitCyc(4);
    testReset();
    testDeselect();
    for (int b = 0; b < 4; b++) testRead(2'(b), 11'(13 * b + 7));
    testWrite(2'd0, 11'h555, 8'hAA, 1'b0);
    testWrite(2'd3, 11'h7FF, 8'h00, 1'b1);   // oe low during write ignored
    testWrite(2'd2, 11'h000, 8'hFF, 1'b1);
    testLatchOrder();
    testCommand(2'd1, 11'h2AA, 8'h55);
    testCommand(2'd3, 11'h555, 8'hCC);
    testRecall(2'd2);
    testRecall(2'd0);
    checks++;
    if (badPulse != 0) begin
      fails++;
      $display("FAIL R8 multi-bank pulse actual=%0d expected=%0d", badPulse, 0);
    end
    testIllegal();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule